// File: doc/BRIEF.md
# Video DMA Bus Arbiter with CPU Stall

This block decides who may use the main CPU bus while a video DMA engine runs in time slices. Each slice is announced with a start strobe. The strobe carries the slice length in cycles, the DMA kind and a flag saying whether the transfer continues after this slice. Kinds 0 and 1 read their source data over the main bus. While such a slice runs, the main CPU is held in wait. Kinds 2 and 3 (fill and copy) leave the main bus alone. For those kinds the main CPU keeps running and a DMA-busy status bit is raised instead.

A secondary CPU reaches the main bus through an address window in its own 16-bit space. The window covers the video-port page and the upper 32 KB banked area. A secondary request into that window always costs a fixed penalty of wait cycles. If a bus-sourced slice is active, the request is first stalled until the slice ends. If the transfer also continues past the slice, a sticky waiting bit is set. The stall then carries across every later slice and the gaps between them, until the whole transfer completes. A frame strobe drops any end point still pending. Requests outside the window are granted at once.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is held, `main_wait`, `dma_busy`, `sec_wait` and `sec_grant` are low and `sec_state` is 3'b000.
- R2: A slice start of kind 0 or 1 with length L raises `main_wait` in the next cycle. `main_wait` then stays high for exactly L cycles, unless the slice is cut short.
- R3: A slice start of kind 2 or 3 with length L raises `dma_busy` for exactly L cycles, starting in the next cycle, and `main_wait` stays low. The two outputs are never high together.
- R4: A secondary request hits the window when `sec_addr[15]` is 1 or `sec_addr[15:8]` is 8'h7F. A request that misses gives `sec_grant` high in the next cycle, and `sec_wait` stays low.
- R5: A window hit made while no kind 0/1 slice is active raises `sec_wait` for exactly PENALTY cycles (default 45), starting in the next cycle. `sec_grant` is high for one cycle right after that.
- R6: A window hit made while a kind 0/1 slice is active keeps `sec_wait` high until `main_wait` falls. From the cycle in which `main_wait` is first low, it stays high for PENALTY+1 more cycles, and then `sec_grant` pulses.
- R7: A window hit during a kind 0/1 slice whose continue flag is set raises `sec_state[2]` in the next cycle. While that bit is set, `sec_wait` stays high through slice gaps and later slices.
- R8: `dma_done` clears `sec_state[2]` and ends the current slice in the next cycle, unless a slice start comes in the same cycle. In that cycle `main_wait` and `dma_busy` fall together with the end of the secondary stall.
- R9: `frame_start` clears the pending slice end point, so `main_wait` and `dma_busy` are low in the next cycle. A slice start in the same cycle takes priority.
- R10: `sec_state[0]` and `sec_state[1]` copy `sec_rst_ctl` and `sec_busreq_ctl` one cycle later.
- R11: A secondary request made while a previous one is still waiting or being granted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe; drops the slice end point |
| slice_start | input | 1 | Start of a DMA time slice |
| slice_kind | input | 2 | DMA kind: 0/1 bus-sourced, 2/3 fill/copy |
| slice_len | input | CNT_W | Slice length in cycles |
| slice_more | input | 1 | Transfer continues after this slice |
| dma_done | input | 1 | Whole transfer complete |
| sec_req | input | 1 | Secondary CPU access strobe |
| sec_addr | input | 16 | Secondary CPU access address |
| sec_rst_ctl | input | 1 | Secondary CPU reset control level |
| sec_busreq_ctl | input | 1 | Secondary CPU bus-request control level |
| main_wait | output | 1 | Main CPU held in wait |
| dma_busy | output | 1 | Status: fill/copy DMA in progress |
| sec_wait | output | 1 | Secondary CPU held in wait |
| sec_grant | output | 1 | One-cycle grant of the secondary access |
| sec_state | output | 3 | {waiting, bus request, reset} state register |

## Verification
A slice strobe shows on `main_wait` or `dma_busy` one cycle later. A window miss is granted one cycle after the strobe. A window hit with no bus DMA keeps `sec_wait` high for PENALTY cycles and is granted in the cycle after. A stalled hit keeps `sec_wait` high for PENALTY+1 cycles, counted from the first cycle in which `main_wait` is low. The bench drives inputs on the falling edge and reads outputs on the next falling edge. A cycle model, built from these latencies, is stepped on every rising edge, and every output is compared with it in every cycle. The directed cases count the high cycles of each wait signal and check each count against the figures above.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int CNT_W   = 16,
  parameter int PENALTY = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             slice_start,
  input  logic [1:0]       slice_kind,
  input  logic [CNT_W-1:0] slice_len,
  input  logic             slice_more,
  input  logic             dma_done,
  input  logic             sec_req,
  input  logic [15:0]      sec_addr,
  input  logic             sec_rst_ctl,
  input  logic             sec_busreq_ctl,
  output logic             main_wait,
  output logic             dma_busy,
  output logic             sec_wait,
  output logic             sec_grant,
  output logic [2:0]       sec_state
);

  localparam int PW = $clog2(PENALTY + 1);
  localparam logic [PW-1:0] PEN_LOAD = PW'(PENALTY);

  typedef enum logic [1:0] {PH_IDLE, PH_STALL, PH_PEN, PH_GRANT} phase_t;

  logic [CNT_W-1:0] left_q;
  logic [1:0]       kind_q;
  logic             more_q;
  logic             sticky_q;
  logic             rst_q, brq_q;
  phase_t           ph_q;
  logic [PW-1:0]    pen_q;

  wire active   = left_q != '0;
  wire bus_dma  = active && !kind_q[1];
  wire win_hit  = sec_addr[15] || (sec_addr[15:8] == 8'h7F);
  wire take_req = (ph_q == PH_IDLE) && sec_req;
  wire held     = bus_dma || sticky_q;

  assign main_wait = bus_dma;
  assign dma_busy  = active && kind_q[1];
  assign sec_wait  = (ph_q == PH_STALL) || (ph_q == PH_PEN);
  assign sec_grant = ph_q == PH_GRANT;
  assign sec_state = {sticky_q, brq_q, rst_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      kind_q <= '0;
      more_q <= 1'b0;
    end else if (slice_start) begin
      left_q <= slice_len;
      kind_q <= slice_kind;
      more_q <= slice_more;
    end else if (frame_start || dma_done) begin
      left_q <= '0;
    end else if (active) begin
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      rst_q    <= 1'b0;
      brq_q    <= 1'b0;
    end else begin
      rst_q <= sec_rst_ctl;
      brq_q <= sec_busreq_ctl;
      if (dma_done)
        sticky_q <= 1'b0;
      else if (take_req && win_hit && bus_dma && more_q)
        sticky_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      pen_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (sec_req) begin
          if (!win_hit) ph_q <= PH_GRANT;
          else if (bus_dma) ph_q <= PH_STALL;
          else begin
            ph_q  <= PH_PEN;
            pen_q <= PEN_LOAD;
          end
        end
        PH_STALL: if (!held) begin
          ph_q  <= PH_PEN;
          pen_q <= PEN_LOAD;
        end
        PH_PEN: begin
          if (pen_q == PW'(1)) ph_q <= PH_GRANT;
          else pen_q <= pen_q - 1'b1;
        end
        PH_GRANT: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R3
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_wait && dma_busy));

  // R7
  sticky_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_state[2]) |-> $past(main_wait));

  // R8
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done && !slice_start |=> !sec_state[2] && !main_wait && !dma_busy);

  // R9
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !slice_start |=> !main_wait && !dma_busy);

  // R4
  grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_grant) |-> $past(sec_wait) || $past(sec_req));

endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb_top;
  localparam int CNT_W = 16;
  localparam int PEN   = 45;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, slice_start, slice_more, dma_done, sec_req;
  logic sec_rst_ctl, sec_busreq_ctl;
  logic [1:0] slice_kind;
  logic [CNT_W-1:0] slice_len;
  logic [15:0] sec_addr;
  logic main_wait, dma_busy, sec_wait, sec_grant;
  logic [2:0] sec_state;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_bus_arbiter #(.CNT_W(CNT_W), .PENALTY(PEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slice_start(slice_start),
    .slice_kind(slice_kind), .slice_len(slice_len), .slice_more(slice_more),
    .dma_done(dma_done), .sec_req(sec_req), .sec_addr(sec_addr),
    .sec_rst_ctl(sec_rst_ctl), .sec_busreq_ctl(sec_busreq_ctl),
    .main_wait(main_wait), .dma_busy(dma_busy), .sec_wait(sec_wait),
    .sec_grant(sec_grant), .sec_state(sec_state));

  int m_left, m_kind, m_ph, m_pen;
  bit m_more, m_sticky, m_rst, m_brq;

  function automatic bit hit(input logic [15:0] a);
    return a[15] || (a[15:8] == 8'h7F);
  endfunction

  function automatic bit m_bus();
    return (m_left != 0) && (m_kind < 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int nl = m_left, nk = m_kind, np = m_ph, npen = m_pen;
    bit nm = m_more, ns = m_sticky;
    if (dma_done) ns = 0;
    else if (m_ph == 0 && sec_req && hit(sec_addr) && m_bus() && m_more) ns = 1;
    case (m_ph)
      0: if (sec_req) begin
           if (!hit(sec_addr)) np = 3;
           else if (m_bus()) np = 1;
           else begin np = 2; npen = PEN; end
         end
      1: if (!(m_bus() || m_sticky)) begin np = 2; npen = PEN; end
      2: if (m_pen == 1) np = 3; else npen = m_pen - 1;
      default: np = 0;
    endcase
    if (slice_start) begin nl = int'(slice_len); nk = int'(slice_kind); nm = slice_more; end
    else if (frame_start || dma_done) nl = 0;
    else if (m_left != 0) nl = m_left - 1;
    m_rst = sec_rst_ctl; m_brq = sec_busreq_ctl;
    m_left = nl; m_kind = nk; m_more = nm; m_sticky = ns; m_ph = np; m_pen = npen;
  endtask

  task automatic compare();
    bit e_mw = m_bus();
    bit e_db = (m_left != 0) && (m_kind >= 2);
    bit e_sw = (m_ph == 1) || (m_ph == 2);
    bit e_sg = (m_ph == 3);
    int e_st = {m_sticky, m_brq, m_rst};
    check(main_wait == e_mw, "R2 main_wait", main_wait, e_mw);
    check(dma_busy == e_db, "R3 dma_busy", dma_busy, e_db);
    check(sec_wait == e_sw, "R6 sec_wait", sec_wait, e_sw);
    check(sec_grant == e_sg, "R5 sec_grant", sec_grant, e_sg);
    check(int'(sec_state) == e_st, "R7 sec_state", sec_state, e_st);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (rst_n) compare();
    frame_start = 0; slice_start = 0; dma_done = 0; sec_req = 0;
  endtask

  task automatic start_slice(input int kind, input int len, input bit more);
    slice_start = 1; slice_kind = 2'(kind); slice_len = CNT_W'(len); slice_more = more;
    tick();
  endtask

  task automatic request(input logic [15:0] a);
    sec_req = 1; sec_addr = a;
    tick();
  endtask

  task automatic count_wait(output int n);
    n = 0;
    while (sec_wait && n < 1000) begin n++; tick(); end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n, seed;
    rst_n = 0; frame_start = 0; slice_start = 0; slice_kind = 0; slice_len = 0;
    slice_more = 0; dma_done = 0; sec_req = 0; sec_addr = 0;
    sec_rst_ctl = 0; sec_busreq_ctl = 0;
    m_left = 0; m_kind = 0; m_ph = 0; m_pen = 0;
    m_more = 0; m_sticky = 0; m_rst = 0; m_brq = 0;
    repeat (4) tick();
    // R1
    check({main_wait, dma_busy, sec_wait, sec_grant} == 4'b0, "R1 outputs", {main_wait, dma_busy, sec_wait, sec_grant}, 0);
    check(sec_state == 3'b0, "R1 sec_state", sec_state, 0);
    rst_n = 1;
    tick();

    // R4: misses granted next cycle
    request(16'h1234);
    check(sec_grant && !sec_wait, "R4 miss grant", {sec_grant, sec_wait}, 2);
    tick();
    request(16'h7EFF);
    check(sec_grant && !sec_wait, "R4 miss 7EFF", {sec_grant, sec_wait}, 2);
    tick();

    // R5: hit with no DMA
    request(16'h7F11);
    count_wait(n);
    check(n == PEN, "R5 idle penalty", n, PEN);
    check(sec_grant == 1, "R5 grant after penalty", sec_grant, 1);
    tick();

    // R3: fill DMA, hit sees only penalty
    start_slice(2, 20, 0);
    check(dma_busy && !main_wait, "R3 fill busy", {dma_busy, main_wait}, 2);
    request(16'h8000);
    count_wait(n);
    check(n == PEN, "R5 fill penalty", n, PEN);
    check(!main_wait, "R3 no main wait", main_wait, 0);
    repeat (3) tick();

    // R2 + R6: single slice
    start_slice(0, 30, 0);
    n = 0;
    while (main_wait && n < 100) begin n++; if (n == 5) sec_req = 1; sec_addr = 16'h9000; tick(); end
    check(n == 30, "R2 main_wait length", n, 30);
    check(sec_wait == 1, "R6 still waiting at fall", sec_wait, 1);
    count_wait(n);
    check(n == PEN + 1, "R6 post-stall wait", n, PEN + 1);
    check(sec_grant && sec_state[2] == 0, "R6 grant no sticky", {sec_grant, sec_state[2]}, 2);
    tick();

    // R7 + R8 + R11: multi-slice DMA
    start_slice(1, 20, 1);
    repeat (3) tick();
    request(16'hC000);
    check(sec_state[2] == 1, "R7 sticky set", sec_state[2], 1);
    n = 0;
    while (main_wait && n < 100) begin n++; tick(); end
    repeat (15) tick();
    check(sec_wait && !main_wait, "R7 held in gap", {sec_wait, main_wait}, 2);
    request(16'h0100);
    check(!sec_grant && sec_wait, "R11 request ignored", {sec_grant, sec_wait}, 1);
    start_slice(1, 20, 1);
    repeat (25) tick();
    check(sec_wait == 1, "R7 held after slice", sec_wait, 1);
    start_slice(1, 10, 0);
    repeat (9) tick();
    dma_done = 1;
    tick();
    check(sec_state[2] == 0 && !main_wait, "R8 done clears", {sec_state[2], main_wait}, 0);
    count_wait(n);
    check(n == PEN + 1, "R8 release penalty", n, PEN + 1);
    tick();

    // R9: frame boundary
    start_slice(0, 50, 0);
    repeat (4) tick();
    frame_start = 1;
    tick();
    check(!main_wait, "R9 frame drops end point", main_wait, 0);
    start_slice(3, 50, 0);
    frame_start = 1;
    tick();
    check(!dma_busy, "R9 frame drops fill", dma_busy, 0);

    // R8: done mid slice
    start_slice(0, 40, 1);
    dma_done = 1;
    tick();
    check(!main_wait, "R8 done ends slice", main_wait, 0);

    // R10
    sec_rst_ctl = 1; sec_busreq_ctl = 1;
    tick();
    check(sec_state[1:0] == 2'b11, "R10 ctl bits", sec_state[1:0], 3);
    sec_rst_ctl = 0;
    tick();
    check(sec_state[1:0] == 2'b10, "R10 ctl bits clear", sec_state[1:0], 2);

    // random phase checked cycle by cycle against the model
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 29) == 0) begin
        slice_start = 1; slice_kind = 2'($urandom_range(0, 3));
        slice_len = CNT_W'($urandom_range(1, 40)); slice_more = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 199) == 0) frame_start = 1;
      if ($urandom_range(0, 79) == 0) dma_done = 1;
      if ($urandom_range(0, 9) == 0) begin
        sec_req = 1; sec_addr = 16'($urandom_range(0, 65535));
        if ($urandom_range(0, 3) == 0) sec_addr[15:8] = 8'h7F;
      end
      if ($urandom_range(0, 49) == 0) sec_busreq_ctl = ~sec_busreq_ctl;
      tick();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule